// File: doc/BRIEF.md
# Indexed Palette Access Port

This block is the host-facing side of a colour lookup unit. A 256-entry table of red/green/blue triples and a separate two-entry cursor palette are reached through a byte-wide register bus with four addresses. The host loads a read pointer or a write pointer. It then moves one colour at a time through a single data address, taking three consecutive accesses for the three components. An internal phase counter records which component comes next. Once a full triple has gone through, the pointer steps to the next entry.

A select input chooses between the two palettes. When it is low, data accesses reach the main table and one shared address holds the pixel mask. When it is high, data accesses reach the cursor palette, the pointers stay where they are after each triple, and the shared address holds a command byte. The pixel pipeline reads the main table through a registered lookup port: the pixel index is ANDed with the mask before the lookup. A second registered port returns cursor colours.

Top module: `pal_port`

## Requirements
- R1: After synchronous reset the mask reads 0xFF, the command byte reads 0x00, both pointers read 0, `rdata` is 0 and the phase is red.
- R2: Writes to the data address (addr 3) are taken as red, then green, then blue. The table entry changes only when blue is written, and it changes to all three components together.
- R3: After the blue access in main-table mode, the pointer that was used increments by one: the write pointer (addr 2) for a write, the read pointer (addr 1) for a read.
- R4: Reads of the data address return the red, green and blue of the entry at the read pointer, in that order, one cycle after the read strobe.
- R5: Writing either pointer register returns the phase to red, discarding any partial triple.
- R6: Pointer increments wrap from 255 to 0.
- R7: With `cur_sel` high, data writes and reads go to cursor entry (pointer bit 0), and the main table is left unchanged.
- R8: With `cur_sel` high, the pointers do not change after a blue access.
- R9: Address 0 is the pixel mask when `cur_sel` is low and the command byte when it is high. Writing one of them leaves the other unchanged.
- R10: `pix_rgb` shows the main-table entry at `pix_idx & mask` one clock after `pix_idx` is presented. The value is packed {red, green, blue}, with red in the top byte.
- R11: `cur_rgb` shows cursor entry `cur_idx` one clock later, packed the same way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cur_sel | input | 1 | Selects the cursor palette and the command byte |
| addr | input | 2 | Register address: 0 mask/command, 1 read pointer, 2 write pointer, 3 data |
| wr_en | input | 1 | Host write strobe; has priority over rd_en |
| rd_en | input | 1 | Host read strobe |
| wdata | input | 8 | Host write data |
| rdata | output | 8 | Host read data, registered |
| pix_idx | input | 8 | Pixel index from the display pipeline |
| pix_rgb | output | 24 | Main-table colour for the masked pixel index |
| cur_idx | input | 1 | Cursor colour select |
| cur_rgb | output | 24 | Cursor palette colour |

## Verification
A phase counter that is out of step shows up at once: the next data read returns the wrong component, or a write lands in the wrong entry with its components rotated. Both are visible on the very next read or lookup. A pointer that steps at the wrong time, or steps in cursor mode, shows in the pointer readback one cycle after the access that caused it. An early commit shows on the pixel port one cycle after the green write, before blue has been sent. Mask and command aliasing appears when the other selection of address 0 is read back.

// File: rtl/pal_pkg.sv
package pal_pkg;

    localparam int CW = 8;
    localparam int IW = 8;
    localparam int AW = 2;

    typedef enum logic [1:0] {
        PH_RED   = 2'd0,
        PH_GREEN = 2'd1,
        PH_BLUE  = 2'd2
    } ph_e;

    typedef struct packed {
        logic [CW-1:0] r;
        logic [CW-1:0] g;
        logic [CW-1:0] b;
    } rgb_t;

    localparam logic [AW-1:0] A_MASKCMD = 2'd0;
    localparam logic [AW-1:0] A_RIDX    = 2'd1;
    localparam logic [AW-1:0] A_WIDX    = 2'd2;
    localparam logic [AW-1:0] A_DATA    = 2'd3;

    function automatic ph_e ph_next(input ph_e p);
        case (p)
            PH_RED:   return PH_GREEN;
            PH_GREEN: return PH_BLUE;
            default:  return PH_RED;
        endcase
    endfunction

    function automatic logic [CW-1:0] rgb_pick(input rgb_t e, input ph_e p);
        case (p)
            PH_RED:   return e.r;
            PH_GREEN: return e.g;
            default:  return e.b;
        endcase
    endfunction

endpackage

// File: rtl/pal_seq.sv
module pal_seq
    import pal_pkg::*;
#(
    parameter int IDX_W = IW
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cur_sel,
    input  logic             ld_ridx,
    input  logic             ld_widx,
    input  logic             dat_wr,
    input  logic             dat_rd,
    input  logic [CW-1:0]    wdata,
    output logic [IDX_W-1:0] rd_idx,
    output logic [IDX_W-1:0] wr_idx,
    output ph_e              phase,
    output logic             commit,
    output logic             commit_cur,
    output logic [IDX_W-1:0] commit_idx,
    output rgb_t             commit_rgb
);

    localparam logic [IDX_W-1:0] ONE = IDX_W'(1);

    logic [CW-1:0] stage_r;
    logic [CW-1:0] stage_g;
    logic          blue_now;

    assign blue_now = (phase == PH_BLUE);

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_idx  <= '0;
            wr_idx  <= '0;
            phase   <= PH_RED;
            stage_r <= '0;
            stage_g <= '0;
        end else if (ld_ridx) begin
            rd_idx <= wdata[IDX_W-1:0];
            phase  <= PH_RED;
        end else if (ld_widx) begin
            wr_idx <= wdata[IDX_W-1:0];
            phase  <= PH_RED;
        end else if (dat_wr) begin
            phase <= ph_next(phase);
            case (phase)
                PH_RED:   stage_r <= wdata;
                PH_GREEN: stage_g <= wdata;
                default:  if (!cur_sel) wr_idx <= wr_idx + ONE;
            endcase
        end else if (dat_rd) begin
            phase <= ph_next(phase);
            if (blue_now && !cur_sel) rd_idx <= rd_idx + ONE;
        end
    end

    always_comb begin
        commit       = dat_wr && blue_now && !ld_ridx && !ld_widx;
        commit_cur   = cur_sel;
        commit_idx   = wr_idx;
        commit_rgb.r = stage_r;
        commit_rgb.g = stage_g;
        commit_rgb.b = wdata;
    end

endmodule

// File: rtl/pal_store.sv
module pal_store
    import pal_pkg::*;
#(
    parameter int IDX_W  = IW,
    parameter int CUR_N  = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             commit,
    input  logic             commit_cur,
    input  logic [IDX_W-1:0] commit_idx,
    input  rgb_t             commit_rgb,
    input  logic             cur_sel,
    input  logic [IDX_W-1:0] rd_idx,
    output rgb_t             host_rgb,
    input  logic [IDX_W-1:0] pix_idx,
    input  logic [IDX_W-1:0] pix_mask,
    output rgb_t             pix_rgb,
    input  logic [$clog2(CUR_N)-1:0] cur_idx,
    output rgb_t             cur_rgb
);

    localparam int DEPTH = 1 << IDX_W;
    localparam int CSW   = $clog2(CUR_N);

    rgb_t tbl  [DEPTH];
    rgb_t curp [CUR_N];

    always_ff @(posedge clk) begin
        if (commit && !commit_cur) tbl[commit_idx] <= commit_rgb;
    end

    for (genvar k = 0; k < CUR_N; k++) begin : g_cur
        always_ff @(posedge clk) begin
            if (rst) begin
                curp[k] <= '0;
            end else if (commit && commit_cur && (commit_idx[CSW-1:0] == CSW'(k))) begin
                curp[k] <= commit_rgb;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pix_rgb <= '0;
            cur_rgb <= '0;
        end else begin
            pix_rgb <= tbl[pix_idx & pix_mask];
            cur_rgb <= curp[cur_idx];
        end
    end

    assign host_rgb = cur_sel ? curp[rd_idx[CSW-1:0]] : tbl[rd_idx];

endmodule

// File: rtl/pal_port.sv
module pal_port
    import pal_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            cur_sel,
    input  logic [AW-1:0]   addr,
    input  logic            wr_en,
    input  logic            rd_en,
    input  logic [CW-1:0]   wdata,
    output logic [CW-1:0]   rdata,
    input  logic [IW-1:0]   pix_idx,
    output logic [3*CW-1:0] pix_rgb,
    input  logic            cur_idx,
    output logic [3*CW-1:0] cur_rgb
);

    localparam int CUR_N = 2;

    logic          do_rd;
    logic          ld_ridx;
    logic          ld_widx;
    logic          dat_wr;
    logic          dat_rd;
    logic [IW-1:0] rd_idx;
    logic [IW-1:0] wr_idx;
    ph_e           phase;
    logic          commit;
    logic          commit_cur;
    logic [IW-1:0] commit_idx;
    rgb_t          commit_rgb;
    rgb_t          host_rgb;
    rgb_t          pix_q;
    rgb_t          cur_q;
    logic [IW-1:0] mask_q;
    logic [CW-1:0] cmd_q;

    assign do_rd   = rd_en && !wr_en;
    assign ld_ridx = wr_en && (addr == A_RIDX);
    assign ld_widx = wr_en && (addr == A_WIDX);
    assign dat_wr  = wr_en && (addr == A_DATA);
    assign dat_rd  = do_rd && (addr == A_DATA);

    pal_seq #(.IDX_W(IW)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .cur_sel    (cur_sel),
        .ld_ridx    (ld_ridx),
        .ld_widx    (ld_widx),
        .dat_wr     (dat_wr),
        .dat_rd     (dat_rd),
        .wdata      (wdata),
        .rd_idx     (rd_idx),
        .wr_idx     (wr_idx),
        .phase      (phase),
        .commit     (commit),
        .commit_cur (commit_cur),
        .commit_idx (commit_idx),
        .commit_rgb (commit_rgb)
    );

    pal_store #(.IDX_W(IW), .CUR_N(CUR_N)) u_store (
        .clk        (clk),
        .rst        (rst),
        .commit     (commit),
        .commit_cur (commit_cur),
        .commit_idx (commit_idx),
        .commit_rgb (commit_rgb),
        .cur_sel    (cur_sel),
        .rd_idx     (rd_idx),
        .host_rgb   (host_rgb),
        .pix_idx    (pix_idx),
        .pix_mask   (mask_q),
        .pix_rgb    (pix_q),
        .cur_idx    (cur_idx),
        .cur_rgb    (cur_q)
    );

    assign pix_rgb = pix_q;
    assign cur_rgb = cur_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '1;
            cmd_q  <= '0;
        end else if (wr_en && addr == A_MASKCMD) begin
            if (cur_sel) cmd_q  <= wdata;
            else         mask_q <= wdata[IW-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata <= '0;
        end else if (do_rd) begin
            case (addr)
                A_MASKCMD: rdata <= cur_sel ? cmd_q : CW'(mask_q);
                A_RIDX:    rdata <= CW'(rd_idx);
                A_WIDX:    rdata <= CW'(wr_idx);
                default:   rdata <= rgb_pick(host_rgb, phase);
            endcase
        end
    end

endmodule

// File: rtl/pal_port_chk.sv
module pal_port_chk
    import pal_pkg::*;
(
    input logic          clk,
    input logic          rst,
    input logic          cur_sel,
    input logic [AW-1:0] addr,
    input logic          wr_en,
    input logic          rd_en,
    input logic [IW-1:0] rd_idx,
    input logic [IW-1:0] wr_idx,
    input ph_e           phase,
    input logic [IW-1:0] mask_q
);

    AST_MASK_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (mask_q == '1 && phase == PH_RED)); // R1

    AST_WIDX_STEP: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == A_DATA && phase == PH_BLUE && !cur_sel)
        |=> (wr_idx == $past(wr_idx) + IW'(1))); // R3

    AST_RIDX_STEP: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !wr_en && addr == A_DATA && phase == PH_BLUE && !cur_sel)
        |=> (rd_idx == $past(rd_idx) + IW'(1))); // R3

    AST_PHASE_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (wr_en && (addr == A_RIDX || addr == A_WIDX)) |=> (phase == PH_RED)); // R5

    AST_CUR_NO_STEP: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == A_DATA && cur_sel) |=> $stable(wr_idx) && $stable(rd_idx)); // R8

    AST_MASK_KEEP: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == A_MASKCMD && cur_sel) |=> $stable(mask_q)); // R9

endmodule

bind pal_port pal_port_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .cur_sel (cur_sel),
    .addr    (addr),
    .wr_en   (wr_en),
    .rd_en   (rd_en),
    .rd_idx  (rd_idx),
    .wr_idx  (wr_idx),
    .phase   (phase),
    .mask_q  (mask_q)
);

// File: tb/pal_port_bench.sv
`timescale 1ns/1ps
module pal_port_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cur_sel = 1'b0;
    logic [1:0]  addr = '0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic [7:0]  pix_idx = '0;
    logic [23:0] pix_rgb;
    logic        cur_idx = 1'b0;
    logic [23:0] cur_rgb;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        logic [7:0] val;
        string      tag;
    } exp_t;

    exp_t exp_q[$];

    always #2 clk = ~clk;

    pal_port u_pal_port (
        .clk     (clk),
        .rst     (rst),
        .cur_sel (cur_sel),
        .addr    (addr),
        .wr_en   (wr_en),
        .rd_en   (rd_en),
        .wdata   (wdata),
        .rdata   (rdata),
        .pix_idx (pix_idx),
        .pix_rgb (pix_rgb),
        .cur_idx (cur_idx),
        .cur_rgb (cur_rgb)
    );

    task automatic chk(input logic [23:0] act, input logic [23:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic hw(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic hr(input logic [1:0] a, input logic [7:0] e, input string tag);
        exp_t it;
        @(negedge clk);
        it.val = e; it.tag = tag;
        exp_q.push_back(it);
        addr = a; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic pk(input logic [7:0] idx, input logic [23:0] e, input string tag);
        @(negedge clk);
        pix_idx = idx;
        @(negedge clk);
        chk(pix_rgb, e, tag);
    endtask

    task automatic ck(input logic idx, input logic [23:0] e, input string tag);
        @(negedge clk);
        cur_idx = idx;
        @(negedge clk);
        chk(cur_rgb, e, tag);
    endtask

    task automatic sel(input logic v);
        @(negedge clk);
        cur_sel = v;
    endtask

    task automatic put3(input logic [7:0] r, input logic [7:0] g, input logic [7:0] b);
        hw(2'd3, r); hw(2'd3, g); hw(2'd3, b);
    endtask

    // monitor: pops one expectation per host read, compares after the capturing edge
    initial begin
        forever begin
            @(posedge clk);
            if (rd_en) begin
                exp_t it;
                @(negedge clk);
                it = exp_q.pop_front();
                chk({16'h0, rdata}, {16'h0, it.val}, it.tag);
            end
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual hung expected finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        chk({16'h0, rdata}, 24'h0, "R1 rdata");
        hr(2'd0, 8'hFF, "R1 mask");
        hr(2'd1, 8'h00, "R1 read pointer");
        hr(2'd2, 8'h00, "R1 write pointer");
        sel(1'b1);
        hr(2'd0, 8'h00, "R1 command");
        sel(1'b0);

        // R2 commit only on blue
        hw(2'd2, 8'd5);
        put3(8'h01, 8'h02, 8'h03);
        hw(2'd2, 8'd5);
        hw(2'd3, 8'h11); hw(2'd3, 8'h22);
        pk(8'd5, 24'h010203, "R2 no commit before blue");
        hw(2'd3, 8'h33);
        pk(8'd5, 24'h112233, "R2 commit after blue");
        hr(2'd2, 8'd6, "R3 write pointer step");

        // R4 read order, R3 read pointer step
        hw(2'd1, 8'd5);
        hr(2'd3, 8'h11, "R4 red");
        hr(2'd3, 8'h22, "R4 green");
        hr(2'd3, 8'h33, "R4 blue");
        hr(2'd1, 8'd6, "R3 read pointer step");

        // R5 pointer load restarts the phase
        hw(2'd2, 8'd7);
        hw(2'd3, 8'hAA);
        hw(2'd2, 8'd7);
        put3(8'h44, 8'h55, 8'h66);
        pk(8'd7, 24'h445566, "R5 write phase restart");
        hw(2'd1, 8'd5);
        hr(2'd3, 8'h11, "R5 read red");
        hw(2'd1, 8'd5);
        hr(2'd3, 8'h11, "R5 read red again");

        // R6 wrap
        hw(2'd2, 8'd255);
        put3(8'h9A, 8'h9B, 8'h9C);
        hr(2'd2, 8'd0, "R6 write wrap");
        pk(8'd255, 24'h9A9B9C, "R6 last entry");
        hw(2'd1, 8'd255);
        hr(2'd3, 8'h9A, "R6 red");
        hr(2'd3, 8'h9B, "R6 green");
        hr(2'd3, 8'h9C, "R6 blue");
        hr(2'd1, 8'd0, "R6 read wrap");

        // R9 mask / command aliasing
        hw(2'd0, 8'h0F);
        sel(1'b1);
        hw(2'd0, 8'hA5);
        hr(2'd0, 8'hA5, "R9 command");
        sel(1'b0);
        hr(2'd0, 8'h0F, "R9 mask kept");

        // R10 masked pixel lookup
        pk(8'h17, 24'h445566, "R10 masked index");
        pk(8'hF5, 24'h112233, "R10 masked index high");
        hw(2'd0, 8'hFF);
        pk(8'hFF, 24'h9A9B9C, "R10 full mask");

        // R7 R8 R11 cursor palette
        sel(1'b1);
        hw(2'd2, 8'd5);
        put3(8'h70, 8'h71, 8'h72);
        hr(2'd2, 8'd5, "R8 write pointer held");
        hw(2'd2, 8'd4);
        put3(8'h80, 8'h81, 8'h82);
        pk(8'd5, 24'h112233, "R7 main table untouched");
        ck(1'b1, 24'h707172, "R11 cursor entry 1");
        ck(1'b0, 24'h808182, "R11 cursor entry 0");
        hw(2'd1, 8'd5);
        hr(2'd3, 8'h70, "R7 cursor red");
        hr(2'd3, 8'h71, "R7 cursor green");
        hr(2'd3, 8'h72, "R7 cursor blue");
        hr(2'd1, 8'd5, "R8 read pointer held");
        hr(2'd3, 8'h70, "R8 same cursor entry");
        sel(1'b0);

        repeat (4) @(negedge clk);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule